// File: doc/BRIEF.md
# Prioritized Interrupt Request Arbiter

This block gathers level-sensitive interrupt requests from a parameterized number of peripheral sources. Software gives each source a priority level through a small register port. On every clock the block picks the single strongest pending request. It then compares that request's level against the processor's current mask. If the level is strictly greater than the mask, a registered request line to the processor is raised.

When the processor acknowledges while the request line is high, the block stores a code that identifies the winning source in a read-only event register. The handler reads this register to branch to the right service routine. Source requests are levels. A source keeps competing until its own flag is cleared at the peripheral. Acknowledging does not remove a request. The block never changes the mask.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After a synchronous active-low reset, `irq_o` is 0, every priority register reads 0 and the event register reads 0.
- R2: A write to address n, where n < NUM_SRC, sets source n's priority level to `reg_wdata_i`. A read of address n returns that level zero-extended. Address NUM_SRC reads the event code. Writes to address NUM_SRC and above are ignored, and reads of any address above NUM_SRC return 0.
- R3: Among sources that are requesting and have a nonzero level, the one with the largest level is selected.
- R4: When several requesting sources share the largest level, the one with the lowest source index is selected.
- R5: `irq_o` is 1 in the cycle after a clock edge exactly when, at that edge, a source was selected and its level was strictly greater than `mask_i`. An equal level does not raise `irq_o`.
- R6: A source whose level is 0 never takes part in selection, so it can never cause `irq_o` to rise.
- R7: When `ack_i` and `irq_o` are both 1 at a clock edge, the event register takes the value 0x400 + 0x20·n, where n is the index of the source that raised `irq_o`. At every other edge the event register keeps its value, including when `ack_i` is 1 while `irq_o` is 0.
- R8: A request that loses arbitration is kept. Once the stronger requests drop, it is selected and raises `irq_o`.
- R9: Acknowledging does not clear `irq_o`. While the winning source keeps requesting above the mask, `irq_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_req_i | input | NUM_SRC | Level request from each source |
| mask_i | input | LVL_W | Processor interrupt mask level |
| ack_i | input | 1 | Processor acceptance strobe |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | ADDR_W | Register address (priority n at n, event code at NUM_SRC) |
| reg_wdata_i | input | LVL_W | Priority level to write |
| reg_rdata_o | output | DATA_W | Read data for `reg_addr_i` |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The hardest situation to reach from the ports is one where a lower-priority request has been pending behind a stronger one through one or more acknowledges. The stronger one then drops, and the event code must change to the source that was waiting. The stimulus holds two sources high at different levels and acknowledges the stronger one. It then removes only that request and acknowledges again. It also sets up an exact tie, and a mask equal to the winner's level, to probe the strict comparison. A long stretch of random requests, masks, acknowledges and priority writes then runs against a behavioural reference model that is compared every clock.

// File: rtl/irq_arb_pkg.sv
// Package: constants and helpers shared by the interrupt arbiter.
// Assumes event codes fit in CODE_W bits for every legal source index.
package irq_arb_pkg;

    localparam int CODE_W    = 16;
    localparam int CODE_BASE = 'h400;
    localparam int CODE_STEP = 'h20;

    // Event code that identifies source idx to the handler.
    function automatic logic [CODE_W-1:0] evt_code(input int unsigned idx);
        return CODE_W'(CODE_BASE + CODE_STEP * idx);
    endfunction

endpackage

// File: rtl/irq_prio_bank.sv
// Module: irq_prio_bank
// Holds one programmable priority level per source.
// Assumes a single write port; an address outside 0..NUM_SRC-1 changes nothing.
module irq_prio_bank #(
    parameter int NUM_SRC = 8,
    parameter int LVL_W   = 4,
    parameter int ADDR_W  = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we_i,
    input  logic [ADDR_W-1:0]               addr_i,
    input  logic [LVL_W-1:0]                wdata_i,
    output logic [NUM_SRC-1:0][LVL_W-1:0]   prio_o
);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_entry
        // Load this source's level when its address is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prio_o[g] <= '0;
            end else if (we_i && (addr_i == ADDR_W'(g))) begin
                prio_o[g] <= wdata_i;
            end
        end
    end

endmodule

// File: rtl/irq_prio_select.sv
// Module: irq_prio_select
// Combinational pick of the strongest pending request.
// A level of 0 disables a source. On equal levels the lowest index wins.
module irq_prio_select #(
    parameter int NUM_SRC = 8,
    parameter int LVL_W   = 4,
    parameter int ID_W    = 3
) (
    input  logic [NUM_SRC-1:0]              req_i,
    input  logic [NUM_SRC-1:0][LVL_W-1:0]   prio_i,
    output logic                            sel_valid_o,
    output logic [LVL_W-1:0]                sel_lvl_o,
    output logic [ID_W-1:0]                 sel_id_o
);

    logic [NUM_SRC-1:0] live;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_live
        // A source is live when it requests with a nonzero level.
        assign live[g] = req_i[g] && (prio_i[g] != '0);
    end

    // Scan from the top index down so that lower indices win ties.
    always_comb begin
        sel_valid_o = 1'b0;
        sel_lvl_o   = '0;
        sel_id_o    = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (live[i] && (prio_i[i] >= sel_lvl_o)) begin
                sel_valid_o = 1'b1;
                sel_lvl_o   = prio_i[i];
                sel_id_o    = ID_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_accept.sv
// Module: irq_accept
// Registers the request to the processor and latches the event code on acceptance.
// Assumes ack is only meaningful while the registered request is high.
module irq_accept
    import irq_arb_pkg::*;
#(
    parameter int LVL_W = 4,
    parameter int ID_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_valid_i,
    input  logic [LVL_W-1:0]  sel_lvl_i,
    input  logic [ID_W-1:0]   sel_id_i,
    input  logic [LVL_W-1:0]  mask_i,
    input  logic              ack_i,
    output logic              irq_o,
    output logic [ID_W-1:0]   win_id_o,
    output logic [CODE_W-1:0] evt_o
);

    // Compare against the mask, hold the winner, and capture its code on ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o    <= 1'b0;
            win_id_o <= '0;
            evt_o    <= '0;
        end else begin
            irq_o    <= sel_valid_i && (sel_lvl_i > mask_i);
            win_id_o <= sel_id_i;
            if (ack_i && irq_o) begin
                evt_o <= evt_code(int'(win_id_o));
            end
        end
    end

endmodule

// File: rtl/irq_prio_arbiter.sv
// Module: irq_prio_arbiter (top)
// Level-sensitive interrupt arbiter with programmable priorities, a strict
// mask compare and an event code register. Assumes DATA_W >= CODE_W.
module irq_prio_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int LVL_W   = 4,
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req_i,
    input  logic [LVL_W-1:0]   mask_i,
    input  logic               ack_i,
    input  logic               reg_we_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [LVL_W-1:0]   reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic               irq_o
);

    localparam int ID_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [NUM_SRC-1:0][LVL_W-1:0] prio;
    logic                          sel_valid;
    logic [LVL_W-1:0]              sel_lvl;
    logic [ID_W-1:0]               sel_id;
    logic [ID_W-1:0]               win_id;
    logic [CODE_W-1:0]             evt;

    irq_prio_bank #(
        .NUM_SRC (NUM_SRC),
        .LVL_W   (LVL_W),
        .ADDR_W  (ADDR_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (reg_we_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .prio_o  (prio)
    );

    irq_prio_select #(
        .NUM_SRC (NUM_SRC),
        .LVL_W   (LVL_W),
        .ID_W    (ID_W)
    ) u_select (
        .req_i       (src_req_i),
        .prio_i      (prio),
        .sel_valid_o (sel_valid),
        .sel_lvl_o   (sel_lvl),
        .sel_id_o    (sel_id)
    );

    irq_accept #(
        .LVL_W (LVL_W),
        .ID_W  (ID_W)
    ) u_accept (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_valid_i (sel_valid),
        .sel_lvl_i   (sel_lvl),
        .sel_id_i    (sel_id),
        .mask_i      (mask_i),
        .ack_i       (ack_i),
        .irq_o       (irq_o),
        .win_id_o    (win_id),
        .evt_o       (evt)
    );

    // Read mux: priority levels, then the event code, zero elsewhere.
    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i < ADDR_W'(NUM_SRC)) begin
            reg_rdata_o = DATA_W'(prio[reg_addr_i[ID_W-1:0]]);
        end else if (reg_addr_i == ADDR_W'(NUM_SRC)) begin
            reg_rdata_o = DATA_W'(evt);
        end
    end

endmodule

// File: rtl/irq_prio_arbiter_chk.sv
// Module: irq_prio_arbiter_chk
// Property checker bound into irq_prio_arbiter. It watches the selection,
// the registered request and the event register. It drives nothing.
module irq_prio_arbiter_chk
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int LVL_W   = 4,
    parameter int ID_W    = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SRC-1:0]            src_req_i,
    input  logic [LVL_W-1:0]              mask_i,
    input  logic                          ack_i,
    input  logic                          irq_o,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] prio,
    input  logic                          sel_valid,
    input  logic [LVL_W-1:0]              sel_lvl,
    input  logic [ID_W-1:0]               sel_id,
    input  logic [ID_W-1:0]               win_id,
    input  logic [CODE_W-1:0]             evt
);

    logic armed;
    logic any_live;
    logic beaten;

    // Arm the $past-based checks one cycle after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // Look for any live source that should beat the reported selection.
    always_comb begin
        any_live = 1'b0;
        beaten   = 1'b0;
        for (int j = 0; j < NUM_SRC; j++) begin
            if (src_req_i[j] && (prio[j] != '0)) begin
                any_live = 1'b1;
                if ((prio[j] > sel_lvl) ||
                    ((prio[j] == sel_lvl) && (j < int'(sel_id)))) begin
                    beaten = 1'b1;
                end
            end
        end
    end

    assert_sel_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (src_req_i[sel_id] && (prio[sel_id] == sel_lvl)));

    assert_sel_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> !beaten);

    assert_zero_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (sel_lvl != '0));

    assert_pending_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        any_live |-> sel_valid);

    assert_irq_gate_R5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        irq_o |-> ($past(sel_valid) && ($past(sel_lvl) > $past(mask_i))));

    assert_irq_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && (sel_lvl > mask_i)) |=> irq_o);

    assert_evt_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o) |=> (evt == evt_code(int'($past(win_id)))));

    assert_evt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_i && irq_o) |=> $stable(evt));

endmodule

bind irq_prio_arbiter irq_prio_arbiter_chk #(
    .NUM_SRC (NUM_SRC),
    .LVL_W   (LVL_W),
    .ID_W    (ID_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_req_i (src_req_i),
    .mask_i    (mask_i),
    .ack_i     (ack_i),
    .irq_o     (irq_o),
    .prio      (prio),
    .sel_valid (sel_valid),
    .sel_lvl   (sel_lvl),
    .sel_id    (sel_id),
    .win_id    (win_id),
    .evt       (evt)
);

// File: tb/irq_prio_arbiter_test.sv
// Bench for irq_prio_arbiter: a behavioural reference model compared every clock,
// plus directed checks on the corner cases.
module irq_prio_arbiter_test;

    localparam int N  = 8;
    localparam int LW = 4;
    localparam int DW = 16;
    localparam int AW = $clog2(N + 1);
    localparam int EVT_A = N;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic [LW-1:0] mask = '0;
    logic          ack = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [LW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // Reference model state
    int m_prio[N];
    int m_irq = 0;
    int m_win = 0;
    int m_evt = 0;

    always #2 clk = ~clk;

    irq_prio_arbiter #(.NUM_SRC(N), .LVL_W(LW), .DATA_W(DW)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_req_i   (req),
        .mask_i      (mask),
        .ack_i       (ack),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic chk(input string tag, input int act, input int exp, input string what);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic int model_read(input int a);
        if (a < N) return m_prio[a];
        if (a == EVT_A) return m_evt;
        return 0;
    endfunction

    // One clock: advance the model at the edge, compare at the falling edge.
    task automatic tick(input string tag);
        int best;
        int idx;
        @(posedge clk);
        if (!rst_n) begin
            foreach (m_prio[i]) m_prio[i] = 0;
            m_irq = 0; m_win = 0; m_evt = 0;
        end else begin
            if (ack && (m_irq != 0)) m_evt = 'h400 + 'h20 * m_win;
            best = 0; idx = 0;
            for (int i = 0; i < N; i++)
                if (req[i] && (m_prio[i] > best)) begin best = m_prio[i]; idx = i; end
            m_irq = (best > int'(mask)) ? 1 : 0;
            m_win = idx;
            if (we && (int'(addr) < N)) m_prio[addr] = int'(wdata);
        end
        @(negedge clk);
        if (rst_n) begin
            chk(tag, int'(irq), m_irq, "irq_o vs model");
            chk(tag, int'(rdata), model_read(int'(addr)), "rdata vs model");
        end
    endtask

    task automatic wr(input int a, input int v, input string tag);
        we = 1'b1; addr = AW'(a); wdata = LW'(v);
        tick(tag);
        we = 1'b0;
    endtask

    task automatic rd(input int a, input int exp, input string tag);
        addr = AW'(a);
        tick(tag);
        chk(tag, int'(rdata), exp, "register read");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) tick("R1");
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", int'(irq), 0, "irq after reset");
        for (int i = 0; i <= N; i++) rd(i, 0, "R1");

        // R2: program, read back, ignored writes
        wr(0, 3, "R2"); wr(1, 5, "R2"); wr(2, 5, "R2"); wr(3, 'hA, "R2");
        rd(1, 5, "R2"); rd(3, 'hA, "R2");
        wr(EVT_A, 'hF, "R2"); rd(EVT_A, 0, "R2");
        wr(EVT_A + 1, 'hF, "R2"); rd(EVT_A + 1, 0, "R2");
        for (int i = 0; i < N; i++) rd(i, (i == 0) ? 3 : (i == 1 || i == 2) ? 5 : (i == 3) ? 'hA : 0, "R2");

        // R3: highest level wins, event code captured on ack
        addr = AW'(EVT_A);
        req = 8'b0000_0011; mask = 0;
        tick("R3");
        chk("R3", int'(irq), 1, "irq raised");
        ack = 1'b1; tick("R7"); ack = 1'b0;
        chk("R7", int'(rdata), 'h420, "event code of source 1");
        chk("R9", int'(irq), 1, "irq held after ack");

        // R4: tie between sources 1 and 2 picks 1
        req = 8'b0000_0110;
        tick("R4");
        ack = 1'b1; tick("R4"); ack = 1'b0;
        chk("R4", int'(rdata), 'h420, "tie winner is source 1");

        // R5: strict mask compare
        req = 8'b0000_0010; mask = 5;
        tick("R5"); tick("R5");
        chk("R5", int'(irq), 0, "level equal to mask");
        mask = 4; tick("R5");
        chk("R5", int'(irq), 1, "level above mask");

        // R7: ack while irq low leaves the event code alone
        mask = 'hF; tick("R7");
        ack = 1'b1; tick("R7"); tick("R7"); ack = 1'b0;
        chk("R7", int'(rdata), 'h420, "event held on idle ack");

        // R6: level-0 source never requests
        mask = 0; req = 8'b0010_0000;
        tick("R6"); tick("R6");
        chk("R6", int'(irq), 0, "disabled source");

        // R8: loser stays pending
        req = 8'b0000_1001;
        tick("R8");
        ack = 1'b1; tick("R8"); ack = 1'b0;
        chk("R8", int'(rdata), 'h460, "source 3 accepted first");
        req = 8'b0000_0001;
        tick("R8");
        chk("R8", int'(irq), 1, "waiting source raises irq");
        ack = 1'b1; tick("R8"); ack = 1'b0;
        chk("R8", int'(rdata), 'h400, "source 0 accepted next");

        // R9: repeated acks do not drop a live request
        ack = 1'b1; repeat (4) tick("R9"); ack = 1'b0;
        chk("R9", int'(irq), 1, "irq after repeated acks");
        req = '0; tick("R9");
        chk("R9", int'(irq), 0, "irq drops with source");

        // Random traffic against the model
        for (int k = 0; k < 2000; k++) begin
            req  = N'($urandom);
            mask = LW'($urandom_range(0, 9));
            ack  = ($urandom_range(0, 2) == 0);
            we   = ($urandom_range(0, 7) == 0);
            addr = AW'($urandom_range(0, N + 2));
            wdata = LW'($urandom);
            tick("R3");
        end
        we = 1'b0; ack = 1'b0;

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule